// File: doc/BRIEF.md
# Address-Decoded Wait-State Generator

This block drives the ready input of an 8-bit CPU core. It watches the address bus and the read and write strobes. When a bus cycle addresses a slow device, it pulls ready low for a set number of whole clock cycles. The clock keeps its full rate throughout. The core idles while ready is low and finishes the access on the first rising edge that sees ready high. Bus cycles to every other address run with no delay.

The slow devices are described by a parameterised table of address windows. Each window has a base, a compare mask, a wait count for reads and a wait count for writes. When windows overlap, the lowest-numbered window wins. The default table has two windows:

- Window 0 covers 0xD000 to 0xD0FF. Reads wait 1 cycle and writes wait 0 cycles.
- Window 1 covers 0xC000 to 0xDFFF. Reads wait 3 cycles and writes wait 2 cycles.

Three cycles cover a 70 ns access at a period of about 25.7 ns. Stretching the clock instead would add delay to the clock path and would risk glitches when switching; holding ready low avoids both.

Top module: `waitstate_gen`

## Requirements
- R1: After reset, and after a reset that cuts a wait short, ready is high while the bus is idle, and the next slow access gets its full wait count.
- R2: With both strobes low, ready stays high at any address, including addresses inside a slow window.
- R3: An access whose address matches no window (for example 0xE000, 0xBFFF or 0x0000) never pulls ready low.
- R4: A read in window 1 (0xC000–0xDFFF outside 0xD000–0xD0FF) holds ready low for exactly 3 cycles. The first low cycle is the cycle in which the access first appears, and ready is high in the fourth cycle.
- R5: A write in window 1 holds ready low for exactly 2 cycles.
- R6: A read in window 0 (0xD000–0xD0FF) holds ready low for exactly 1 cycle. A write in window 0 has a wait count of zero and never pulls ready low.
- R7: Where windows overlap, the lowest-numbered window sets the count. 0xD100 lies only in window 1 and a read there waits 3 cycles.
- R8: Back-to-back slow accesses, with no idle cycle between them, each get their own full wait count.
- R9: If the strobes drop during a wait, ready returns high in that same cycle. The next access starts a fresh full count.
- R10: If both strobes are high, the read count of the window applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | CPU address bus |
| rd_en | input | 1 | Read strobe of the current bus cycle |
| wr_en | input | 1 | Write strobe of the current bus cycle |
| rdy | output | 1 | Ready to the CPU; low means hold the current bus cycle |

## Verification
Ready is a combinational result of the inputs and the wait state. It falls in the same cycle that a slow access is driven, and each counter update takes effect one rising edge later. The bench drives inputs on the falling edge and samples ready 1 ns later. It counts one low cycle per falling edge until ready is seen high. The access then completes on the next rising edge, and the bench takes the following falling edge as the start of the next stimulus. Abort and reset cases are sampled in the very cycle of the change, because no register lies between the strobes and ready.

// File: rtl/wsg_pkg.sv
// Package: shared types for the wait-state generator.
// Assumes wait counts fit in WAIT_W bits. The default of 4 bits allows
// up to 15 wait cycles per access.
package wsg_pkg;
    localparam int WAIT_W = 4;

    typedef logic [WAIT_W-1:0] wait_t;

    // Result of the address decode for the current bus cycle
    typedef struct packed {
        logic  hit;
        wait_t rd_wait;
        wait_t wr_wait;
    } region_sel_t;
endpackage

// File: rtl/wsg_region_decode.sv
// Module: wsg_region_decode
// Compares the address with every window of the table. It returns whether
// any window matched and the read and write wait counts of the
// lowest-numbered matching window.
// Assumes that a mask bit set to 1 means the address bit must equal the
// base bit. Purely combinational.
module wsg_region_decode
    import wsg_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int NUM_REGIONS = 2,
    parameter logic [NUM_REGIONS*ADDR_W-1:0] BASE    = '0,
    parameter logic [NUM_REGIONS*ADDR_W-1:0] MASK    = '0,
    parameter logic [NUM_REGIONS*WAIT_W-1:0] RD_WAIT = '0,
    parameter logic [NUM_REGIONS*WAIT_W-1:0] WR_WAIT = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output region_sel_t       sel
);
    logic [NUM_REGIONS-1:0] match;

    // One comparator per window
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        assign match[g] =
            (((addr ^ BASE[g*ADDR_W +: ADDR_W]) & MASK[g*ADDR_W +: ADDR_W]) == '0);
    end

    // Priority pick: scan from the top so the lowest index is written last
    always_comb begin
        sel = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel.hit     = 1'b1;
                sel.rd_wait = RD_WAIT[i*WAIT_W +: WAIT_W];
                sel.wr_wait = WR_WAIT[i*WAIT_W +: WAIT_W];
            end
        end
    end
endmodule

// File: rtl/wsg_wait_counter.sv
// Module: wsg_wait_counter
// Counts the wait cycles of one slow access and drives ready.
// Ready is low from the first cycle the request is seen until the number of
// low cycles reaches the wait count latched at the start of the access.
// Assumes the CPU holds address and strobes while ready is low. If the
// request is withdrawn, the wait ends at once.
module wsg_wait_counter
    import wsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req,
    input  wait_t req_wait,
    output logic  rdy,
    output logic  active,
    output wait_t cnt,
    output wait_t target
);
    // Ready decision for the current cycle
    always_comb begin
        if (!req)         rdy = 1'b1;
        else if (!active) rdy = (req_wait == '0);
        else              rdy = (cnt == target);
    end

    // Wait-state tracking: start, count, release, abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            target <= '0;
        end else if (!active) begin
            if (req && req_wait != '0) begin
                active <= 1'b1;
                cnt    <= wait_t'(1);
                target <= req_wait;
            end
        end else if (!req || cnt == target) begin
            active <= 1'b0;
            cnt    <= '0;
        end else begin
            cnt <= wait_t'(cnt + 1'b1);
        end
    end
endmodule

// File: rtl/waitstate_gen.sv
// Module: waitstate_gen (top)
// Produces the CPU ready signal from the address decode. An access to a
// window in the table is held for the window's read or write wait count.
// When both strobes are high, the read count applies.
// Assumes a single clock domain and a CPU that stalls while ready is low.
module waitstate_gen
    import wsg_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int NUM_REGIONS = 2,
    parameter logic [NUM_REGIONS*ADDR_W-1:0] BASE    = {16'hC000, 16'hD000},
    parameter logic [NUM_REGIONS*ADDR_W-1:0] MASK    = {16'hE000, 16'hFF00},
    parameter logic [NUM_REGIONS*WAIT_W-1:0] RD_WAIT = {4'd3, 4'd1},
    parameter logic [NUM_REGIONS*WAIT_W-1:0] WR_WAIT = {4'd2, 4'd0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic              rdy
);
    region_sel_t sel;
    logic        access;
    logic        dec_hit;
    logic        req;
    wait_t       req_wait;
    logic        active;
    wait_t       cnt;
    wait_t       target;

    wsg_region_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_REGIONS (NUM_REGIONS),
        .BASE        (BASE),
        .MASK        (MASK),
        .RD_WAIT     (RD_WAIT),
        .WR_WAIT     (WR_WAIT)
    ) decode_i (
        .addr (addr),
        .sel  (sel)
    );

    // Request qualification and read-over-write count choice
    always_comb begin
        access   = rd_en | wr_en;
        dec_hit  = sel.hit;
        req      = access & sel.hit;
        req_wait = rd_en ? sel.rd_wait : sel.wr_wait;
    end

    wsg_wait_counter counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wait (req_wait),
        .rdy      (rdy),
        .active   (active),
        .cnt      (cnt),
        .target   (target)
    );
endmodule

// File: rtl/waitstate_gen_chk.sv
// Module: waitstate_gen_chk
// Assertion checker attached to every waitstate_gen instance by bind.
// It relates the ports to the decode result and to the counter state.
module waitstate_gen_chk
    import wsg_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  rd_en,
    input logic  wr_en,
    input logic  rdy,
    input logic  dec_hit,
    input logic  active,
    input wait_t cnt,
    input wait_t target
);
    logic [WAIT_W:0] low_run;

    // Length of the current run of consecutive low-ready cycles
    always_ff @(posedge clk) begin
        if (!rst_n)   low_run <= '0;
        else if (rdy) low_run <= '0;
        else          low_run <= low_run + 1'b1;
    end

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |-> rdy); // R2
    AST_FAST_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !dec_hit) |-> rdy); // R3
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt != '0 && cnt <= target)); // R4
    AST_LOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= {1'b0, {WAIT_W{1'b1}}}); // R4
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rdy) |=> !active); // R8
    AST_ABORT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !(rd_en || wr_en)) |-> rdy); // R9
endmodule

bind waitstate_gen waitstate_gen_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .rdy     (rdy),
    .dec_hit (dec_hit),
    .active  (active),
    .cnt     (cnt),
    .target  (target)
);

// File: tb/waitstate_gen_tb_top.sv
// Bench for waitstate_gen. The vector table gives the expected number of
// low-ready cycles for each single access. Directed tests then cover the
// idle bus, back-to-back accesses, an abort and a reset during a wait.
module waitstate_gen_tb_top;
    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr  = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rdy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Vector layout: {addr[15:0], rd, wr, expected low cycles[5:0]}
    localparam int NV = 12;
    localparam logic [23:0] VEC [NV] = '{
        {16'hC000, 1'b1, 1'b0, 6'd3},
        {16'hC000, 1'b0, 1'b1, 6'd2},
        {16'hCFFF, 1'b1, 1'b0, 6'd3},
        {16'hD000, 1'b1, 1'b0, 6'd1},
        {16'hD0FF, 1'b0, 1'b1, 6'd0},
        {16'hD100, 1'b1, 1'b0, 6'd3},
        {16'hE000, 1'b1, 1'b0, 6'd0},
        {16'hBFFF, 1'b1, 1'b0, 6'd0},
        {16'h0000, 1'b0, 1'b1, 6'd0},
        {16'hDFFF, 1'b0, 1'b1, 6'd2},
        {16'hC123, 1'b1, 1'b1, 6'd3},
        {16'hD050, 1'b1, 1'b1, 6'd1}
    };

    waitstate_gen dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .rdy   (rdy)
    );

    always #4 clk = ~clk;

    function automatic string vtag(int i);
        case (i)
            0, 2:    return "R4";
            1, 9:    return "R5";
            3, 4:    return "R6";
            5:       return "R7";
            6, 7, 8: return "R3";
            default: return "R10";
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts at a falling edge and returns one falling edge after the
    // completing rising edge
    task automatic access(input logic [15:0] a, input logic r, input logic w,
                          output int lows);
        addr  = a;
        rd_en = r;
        wr_en = w;
        lows  = 0;
        #1;
        while (!rdy && lows < 40) begin
            lows++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    task automatic go_idle();
        rd_en = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int l1;
        int l2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rdy == 1'b1, "R1", int'(rdy), 1);
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][23:8], VEC[i][7], VEC[i][6], l1);
            check(l1 == int'(VEC[i][5:0]), vtag(i), l1, int'(VEC[i][5:0]));
            go_idle();
        end

        // R2: idle bus inside a slow window
        addr = 16'hC000;
        for (int k = 0; k < 3; k++) begin
            #1;
            check(rdy == 1'b1, "R2", int'(rdy), 1);
            @(negedge clk);
        end

        // R8: back-to-back same address, then different windows
        access(16'hC000, 1'b1, 1'b0, l1);
        access(16'hC000, 1'b1, 1'b0, l2);
        check(l1 == 3, "R8", l1, 3);
        check(l2 == 3, "R8", l2, 3);
        access(16'hC010, 1'b0, 1'b1, l1);
        access(16'hD010, 1'b1, 1'b0, l2);
        check(l1 == 2, "R8", l1, 2);
        check(l2 == 1, "R8", l2, 1);
        go_idle();

        // R9: strobe withdrawn after one low cycle
        addr  = 16'hC000;
        rd_en = 1'b1;
        #1;
        check(rdy == 1'b0, "R9", int'(rdy), 0);
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        check(rdy == 1'b1, "R9", int'(rdy), 1);
        @(negedge clk);
        access(16'hC000, 1'b1, 1'b0, l1);
        check(l1 == 3, "R9", l1, 3);
        go_idle();

        // R1: reset during a wait
        addr  = 16'hC000;
        rd_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        rd_en = 1'b0;
        #1;
        check(rdy == 1'b1, "R1", int'(rdy), 1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rdy == 1'b1, "R1", int'(rdy), 1);
        @(negedge clk);
        access(16'hC000, 1'b1, 1'b0, l1);
        check(l1 == 3, "R1", l1, 3);
        go_idle();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule